// File: doc/BRIEF.md
# Video Timing Reference Word Aligner

This block sits in the bit-clock domain of a serial video receiver, after clock recovery, descrambling and NRZI decoding. It takes one recovered bit per clock and groups the bits into 20-bit parallel words. Each word holds two interleaved 10-bit samples, and the earliest bit received lands in bit 0. A word strobe accompanies each word.

The block scans a 60-bit sliding window at every bit position for the timing-reference preamble: two samples of all ones followed by four samples of all zeros. When alignment is enabled and the preamble starts at a bit that is not the current word boundary, the boundary is moved onto the preamble. A frame pulse is raised together with the word that carries the first all-ones sample.

With alignment disabled, the boundary never moves. Streams that use other line codes then pass through on a fixed grid. Every word leaves the block after the same delay, and a realignment shows up as a single shortened interval between two strobes.

Top module: `vid_ref_aligner`

## Requirements
- R1: While reset is asserted, `word_out` is zero, `word_stb` is low and `frame_pulse` is low. The boundary phase restarts so that the first bit after reset is bit 0 of a word.
- R2: One bit is taken per clock. Bit i of a word is the (i+1)-th bit received for that word. Without realignment, `word_stb` is high for one cycle every 20 cycles and never goes 20 cycles without a strobe.
- R3: A word's strobe is high in the cycle that follows the 41st rising edge after the edge that sampled the word's last bit. With no realignment, the n-th strobe after reset (counting from 0) therefore carries stream word n-3, and the earlier strobes carry zero.
- R4: The preamble is exactly 20 ones followed by 40 zeros in arrival order (0x3FF, 0x3FF, 0x000, 0x000, 0x000, 0x000 as 10-bit LSB-first samples). A pattern with any bit different is not detected.
- R5: With alignment enabled, a preamble that starts k bits (1 to 19) after the current boundary makes the next strobe come k cycles after the previous one. That strobe's word begins with the first preamble bit.
- R6: A preamble that starts on the current boundary changes nothing: strobe spacing stays 20.
- R7: `frame_pulse` is high for exactly one cycle per detected reference, only together with `word_stb`, on the word whose value is 0xFFFFF. The next two words are zero.
- R8: With alignment disabled, the boundary never moves. A preamble that is off the boundary produces no frame pulse, and the output words equal the fixed-grid words of the stream.
- R9: With alignment disabled, a preamble that lies on the boundary still produces a frame pulse.
- R10: After a realignment, the following words are the payload words that come after the preamble, in order and spaced 20 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_bit | input | 1 | Recovered serial bit, one per clock |
| align_en | input | 1 | High: allow the word boundary to follow the preamble |
| word_out | output | 20 | Parallel word, earliest bit in bit 0 |
| word_stb | output | 1 | One-cycle strobe marking a new `word_out` |
| frame_pulse | output | 1 | Marks the word that carries the first all-ones sample |

## Verification
Preamble detection and the regular word boundary can occur in the same cycle. This happens whenever the preamble starts exactly on the current grid. The bench provokes it with offset 0 in both modes, and again with a second preamble placed a whole number of words after a realignment. In that case the frame pulse must land on the scheduled strobe, with the interval still 20. At every other offset the bench checks that detection alone forces the strobe early by exactly the offset when alignment is on, and that it has no effect on either the grid or the frame pulse when alignment is off.

// File: rtl/var_pkg.sv
package var_pkg;
    typedef enum logic [1:0] {
        EMIT_IDLE = 2'd0,
        EMIT_SLOT = 2'd1,
        EMIT_SNAP = 2'd2
    } emit_e;

    localparam int DEF_SAMPLE_W   = 10;
    localparam int DEF_SAMPLES    = 2;
    localparam int DEF_LEAD_ONES  = 2;
    localparam int DEF_LEAD_ZEROS = 4;
endpackage

// File: rtl/var_window.sv
module var_window #(
    parameter int WIN_W = 60
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_in,
    output logic [WIN_W-1:0] win_q
);
    typedef struct packed {
        logic [WIN_W-1:0] win;
    } win_st_t;

    win_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.win = {bit_in, st_q.win[WIN_W-1:1]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign win_q = st_q.win;

    // newest bit enters at the top of the window (R2)
    assert_new_bit_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st_q.win[WIN_W-1] == $past(bit_in)));

    // older bits move one place towards bit 0 (R2)
    assert_shift_down_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (st_q.win[WIN_W-2:0] == $past(st_q.win[WIN_W-1:1])));
endmodule

// File: rtl/var_detect.sv
module var_detect #(
    parameter int WIN_W  = 60,
    parameter int ONES_W = 20
) (
    input  logic [WIN_W-1:0] win,
    output logic             hit
);
    logic lead_ones;
    logic tail_zero;

    always_comb begin
        lead_ones = &win[ONES_W-1:0];
        tail_zero = ~(|win[WIN_W-1:ONES_W]);
        hit       = lead_ones & tail_zero;
    end
endmodule

// File: rtl/var_phase.sv
module var_phase
    import var_pkg::*;
#(
    parameter int WORD_W = 20
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hit,
    input  logic  align_en,
    output emit_e kind
);
    localparam int POS_W = $clog2(WORD_W);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } ph_st_t;

    ph_st_t st_d, st_q;
    logic [POS_W-1:0] base;

    always_comb begin
        st_d = st_q;
        kind = EMIT_IDLE;
        if (st_q.pos == '0)
            kind = EMIT_SLOT;
        else if (align_en && hit)
            kind = EMIT_SNAP;
        base = (kind != EMIT_IDLE) ? '0 : st_q.pos;
        if (base == POS_W'(WORD_W - 1))
            st_d.pos = '0;
        else
            st_d.pos = base + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // any emitted word restarts the phase count at the following bit (R5)
    assert_phase_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != EMIT_IDLE) |=> (st_q.pos == POS_W'(1)));

    // the phase stays inside one word (R2)
    assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pos < POS_W'(WORD_W));
endmodule

// File: rtl/vid_ref_aligner.sv
module vid_ref_aligner
    import var_pkg::*;
#(
    parameter int SAMPLE_W   = DEF_SAMPLE_W,
    parameter int SAMPLES    = DEF_SAMPLES,
    parameter int LEAD_ONES  = DEF_LEAD_ONES,
    parameter int LEAD_ZEROS = DEF_LEAD_ZEROS
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          ser_bit,
    input  logic                          align_en,
    output logic [SAMPLE_W*SAMPLES-1:0]   word_out,
    output logic                          word_stb,
    output logic                          frame_pulse
);
    localparam int WORD_W = SAMPLE_W * SAMPLES;
    localparam int ONES_W = LEAD_ONES * SAMPLE_W;
    localparam int WIN_W  = (LEAD_ONES + LEAD_ZEROS) * SAMPLE_W;
    localparam int GAP_W  = $clog2(WORD_W + 1);
    localparam int OFF_W  = $clog2(2 * WORD_W + 1);

    logic [WIN_W-1:0] win;
    logic             hit;
    emit_e            kind;
    logic             emit;

    var_window #(.WIN_W(WIN_W)) u_window (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_in (ser_bit),
        .win_q  (win)
    );

    var_detect #(.WIN_W(WIN_W), .ONES_W(ONES_W)) u_detect (
        .win (win),
        .hit (hit)
    );

    var_phase #(.WORD_W(WORD_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .align_en (align_en),
        .kind     (kind)
    );

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              stb;
        logic              fp;
        logic [GAP_W-1:0]  gap;
        logic [OFF_W-1:0]  off_run;
    } out_st_t;

    out_st_t st_d, st_q;

    always_comb begin
        emit     = (kind != EMIT_IDLE);
        st_d     = st_q;
        st_d.stb = emit;
        st_d.fp  = emit & hit;
        if (emit)
            st_d.word = win[WORD_W-1:0];
        if (emit)
            st_d.gap = '0;
        else if (st_q.gap < GAP_W'(WORD_W))
            st_d.gap = st_q.gap + 1'b1;
        if (align_en)
            st_d.off_run = '0;
        else if (st_q.off_run < OFF_W'(2 * WORD_W))
            st_d.off_run = st_q.off_run + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_out    = st_q.word;
    assign word_stb    = st_q.stb;
    assign frame_pulse = st_q.fp;

    // frame pulse rides on a strobe whose word is the all-ones sample pair (R7)
    assert_fp_on_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_pulse |-> (word_stb && (word_out == {WORD_W{1'b1}})));

    // no word is ever longer than the nominal length (R2)
    assert_no_long_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.gap < GAP_W'(WORD_W));

    // with alignment held off, strobes keep the fixed 20-cycle grid (R8)
    assert_fixed_grid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && (st_q.off_run == OFF_W'(2 * WORD_W)))
            |-> ($past(st_q.gap) == GAP_W'(WORD_W - 1)));
endmodule

// File: tb/vid_ref_aligner_test.sv
module vid_ref_aligner_test;
    localparam int CLK_PERIOD = 10;
    localparam int WW = 20;
    localparam logic [19:0] PAY [4] = '{20'h5A5A5, 20'h3C3C3, 20'h12345, 20'hCAFE1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser_bit = 1'b0;
    logic        align_en = 1'b0;
    logic [19:0] word_out;
    logic        word_stb;
    logic        frame_pulse;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_ref_aligner uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ser_bit     (ser_bit),
        .align_en    (align_en),
        .word_out    (word_out),
        .word_stb    (word_stb),
        .frame_pulse (frame_pulse)
    );

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [19:0] cap_w [64];
    bit          cap_f [64];
    int          cap_t [64];
    int          ncap = 0;
    int          ecount = 0;

    bit stream [1024];
    int slen = 0;
    int pre_pos [2];
    bit pre_bad [2];
    int npre = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) ecount <= ecount + 1;

    always @(negedge clk) begin
        if (rst_n && word_stb && ncap < 64) begin
            cap_w[ncap] = word_out;
            cap_f[ncap] = frame_pulse;
            cap_t[ncap] = ecount;
            ncap++;
        end
    end

    task automatic add_word(input logic [19:0] w, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            stream[slen] = w[i];
            slen++;
        end
    endtask

    task automatic add_filler(input int n);
        for (int i = 0; i < n; i++) begin
            stream[slen] = bit'(slen % 2);
            slen++;
        end
    endtask

    task automatic add_pre(input bit bad);
        pre_pos[npre] = slen;
        pre_bad[npre] = bad;
        npre++;
        add_word(20'hFFFFF, 20);
        if (bad) stream[slen-10] = 1'b0;
        add_word(20'h00000, 20);
        add_word(20'h00000, 20);
    endtask

    task automatic build(input int o, input int gap, input bit bad);
        slen = 0;
        npre = 0;
        add_filler(60 + o);
        add_pre(bad);
        for (int k = 0; k < 4; k++) add_word(PAY[k], 20);
        if (gap >= 0) begin
            add_filler(gap);
            add_pre(1'b0);
            for (int k = 0; k < 4; k++) add_word(PAY[k], 20);
        end
        add_filler(80);
    endtask

    function automatic logic [19:0] sword(input int k);
        logic [19:0] w;
        for (int b = 0; b < 20; b++) w[b] = stream[20*k + b];
        return w;
    endfunction

    task automatic run(input bit en);
        align_en = en;
        rst_n = 1'b0;
        ser_bit = 1'b0;
        repeat (3) @(negedge clk);
        ncap = 0;
        // R1: outputs idle while reset is held
        check(word_stb == 1'b0, "R1 stb in reset", int'(word_stb), 0);
        check(frame_pulse == 1'b0, "R1 fp in reset", int'(frame_pulse), 0);
        check(word_out == 20'h0, "R1 word in reset", int'(word_out), 0);
        rst_n = 1'b1;
        ser_bit = stream[0];
        for (int i = 1; i < slen; i++) begin
            @(negedge clk);
            ser_bit = stream[i];
        end
        @(negedge clk);
        ser_bit = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic verify(input bit en, input string mode);
        int base = 0;
        int fi = 0;
        int first_fp = ncap;
        int exp_total = 0;
        int got_total = 0;
        for (int p = 0; p < npre; p++) begin
            int pp = pre_pos[p];
            int d = (pp - base) % WW;
            bit exp_fp = !pre_bad[p] && (en || d == 0);
            int f = -1;
            for (int s = fi; s < ncap; s++) begin
                if (cap_f[s]) begin
                    f = s;
                    break;
                end
            end
            if (exp_fp) begin
                exp_total++;
                check(f >= 0, {"R7 fp present ", mode}, f, 0);
                if (f >= 1 && f + 6 < ncap) begin
                    int exp_int = (d == 0) ? WW : d;
                    if (p == 0) first_fp = f;
                    check(cap_w[f] == 20'hFFFFF, {"R7 fp word ", mode}, int'(cap_w[f]), 20'hFFFFF);
                    check(cap_w[f+1] == 20'h0 && cap_w[f+2] == 20'h0, {"R7 zero words ", mode},
                          int'(cap_w[f+1] | cap_w[f+2]), 0);
                    if (d == 0)
                        check(cap_t[f] - cap_t[f-1] == exp_int, {"R6 on-boundary interval ", mode},
                              cap_t[f] - cap_t[f-1], exp_int);
                    else
                        check(cap_t[f] - cap_t[f-1] == exp_int, {"R5 short word ", mode},
                              cap_t[f] - cap_t[f-1], exp_int);
                    for (int k = 0; k < 4; k++)
                        check(cap_w[f+3+k] == PAY[k], {"R10 payload ", mode}, int'(cap_w[f+3+k]), int'(PAY[k]));
                    for (int k = 1; k <= 6; k++)
                        check(cap_t[f+k] - cap_t[f+k-1] == WW, {"R10 spacing ", mode},
                              cap_t[f+k] - cap_t[f+k-1], WW);
                    base = pp;
                    fi = f + 1;
                end
            end else if (pre_bad[p]) begin
                check(f < 0, {"R4 near-miss ignored ", mode}, f, -1);
            end else begin
                check(f < 0, {"R8 no fp off boundary ", mode}, f, -1);
            end
        end
        for (int s = 0; s < ncap; s++) if (cap_f[s]) got_total++;
        check(got_total == exp_total, {"R7 fp count ", mode}, got_total, exp_total);
        // fixed-grid words before any realignment (R3), whole stream when disabled (R8)
        for (int s = 0; s < ncap && s < first_fp + ((en) ? 0 : ncap); s++) begin
            if (en && s >= first_fp) break;
            if (s >= 3 && (s - 3) * WW + 19 < slen) begin
                logic [19:0] ew = sword(s - 3);
                if (en) check(cap_w[s] == ew, {"R3 grid word ", mode}, int'(cap_w[s]), int'(ew));
                else    check(cap_w[s] == ew, {"R8 fixed word ", mode}, int'(cap_w[s]), int'(ew));
            end else if (s < 3) begin
                check(cap_w[s] == 20'h0, {"R3 early word ", mode}, int'(cap_w[s]), 0);
            end
            if (s >= 1)
                check(cap_t[s] - cap_t[s-1] == WW, {"R2 spacing ", mode}, cap_t[s] - cap_t[s-1], WW);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=expired expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        // sweep every offset with alignment on and off (R5, R6, R8, R9)
        for (int o = 0; o < WW; o++) begin
            for (int en = 0; en < 2; en++) begin
                build(o, -1, 1'b0);
                run(bit'(en));
                if (en == 0 && o == 0) verify(1'b0, "R9 disabled on-boundary");
                else                   verify(bit'(en), $sformatf("off%0d en%0d", o, en));
            end
        end
        // second preamble a whole number of words after realignment (R6)
        build(7, 40, 1'b0);
        run(1'b1);
        verify(1'b1, "R6 repeat same grid");
        // second preamble at a new offset forces another realignment (R5)
        build(7, 45, 1'b0);
        run(1'b1);
        verify(1'b1, "R5 second realign");
        // corrupted preamble must not be detected (R4)
        build(9, -1, 1'b1);
        run(1'b1);
        verify(1'b1, "R4 corrupted");
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule